// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block carries 8-bit companded samples between a codec core and a time-division multiplexed PCM bus. The bus bit clock is the block's clock. Transmit and receive each have their own frame-sync input. After a rising frame sync, a position counter advances once per bit clock. When the count reaches the programmed slot, the transmit lane drives one byte onto the bus and the receive lane collects one byte from it.

The transmit lane drives a bit on each rising edge. The receive lane samples a bit on each falling edge. The receive lane gives a one-cycle valid strobe with each finished byte, and that strobe marks the start of decoding. After the transmit slot ends, the transmit lane gives a one-cycle request. That request starts the next encode, and the core then presents the byte for the following frame. A mode input sets how the slot lines up with frame sync: the slot starts with the frame sync, or one bit clock after it. The serial output goes to high impedance outside its slot and while the block is powered down.

Top module: `pcm_tsi`

## Requirements
- R1: During reset and after it, `dx_en`, `tx_req` and `rx_valid` are 0, and `rx_byte` is 0 until the first received byte.
- R2: The transmit slot covers frame bit positions `tx_slot*8` through `tx_slot*8+7`. In those eight intervals `dx_en` is 1 and `dx` carries the latched byte, most significant bit first. At every other position `dx_en` is 0. No run of `dx_en` lasts longer than 8 cycles.
- R3: When `dly_mode`=0, frame bit position 0 is the bit interval that begins at the rising clock edge where the frame sync is first sampled high after being low.
- R4: When `dly_mode`=1, frame bit position 0 begins one rising edge later than it does when `dly_mode`=0.
- R5: `dr` is sampled on the falling edge inside each bit interval of the receive slot, most significant bit first. After the last bit, in the next interval, `rx_byte` holds the assembled byte and `rx_valid` is 1 for exactly one cycle.
- R6: `tx_req` is 1 for exactly one cycle, in the interval that follows the last bit of the transmit slot.
- R7: `fsx` alone sets the transmit frame position, and `fsr` alone sets the receive frame position. The two can arrive at different times.
- R8: While `pwr_dn` is 1, `dx_en` is 0 from the next rising edge on and `dx` is high impedance (`dx_en`=0 means high impedance). `tx_req` and the receive lane keep running.
- R9: A new rising frame sync in the middle of a frame restarts that direction's position count from the new frame sync.
- R10: `tx_byte` is captured at the rising edge that starts the first bit of the transmit slot. Changes to it later in that slot do not affect `dx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| dly_mode | input | 1 | 0: slot aligned with frame sync; 1: one bit later |
| pwr_dn | input | 1 | Power-down request; turns off the data output |
| tx_slot | input | SLOT_W | Transmit time-slot number |
| rx_slot | input | SLOT_W | Receive time-slot number |
| tx_byte | input | 8 | Byte to send in the transmit slot |
| tx_req | output | 1 | One-cycle pulse after the transmit slot (encode start) |
| dx | output | 1 | Serial PCM output, high impedance when not enabled |
| dx_en | output | 1 | Output enable of dx |
| dr | input | 1 | Serial PCM input |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse with each received byte (decode start) |

## Verification
The bench sweeps both alignment modes over slot pairs that include the first slot, the last slot (63), and slots that differ between transmit and receive. Each interval is checked against positions the bench computes from the frame-sync time.

A design that counted from the wrong edge, or that ignored the mode bit, would shift every byte by one position. Such a shift shows up as wrong `dx` bits, wrong `rx_byte` values, or strobes in the wrong cycle. If the output took `tx_byte` live instead of latching it, the bench would catch it, because the bench flips `tx_byte` in the middle of each slot. Other cases covered:
- Skewed receive frame syncs catch lanes that share one counter.
- A power-down frame catches an enable that is still driven.
- A frame sync repeated in the middle of a frame catches a counter that does not restart.
- Slot 63 catches a counter that wraps or stops early at the end of the frame.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_ARM  = 2'd1,
        FR_RUN  = 2'd2
    } frame_st_e;

    // One bit interval as seen by a lane: inside its slot, and where.
    typedef struct packed {
        logic             hit;
        logic             first;
        logic             last;
        logic [IDX_W-1:0] idx;
    } slot_tap_t;

    function automatic slot_tap_t make_tap(input logic run,
                                           input logic slot_eq,
                                           input logic [IDX_W-1:0] idx);
        slot_tap_t t;
        t.hit   = run & slot_eq;
        t.first = t.hit && (idx == '0);
        t.last  = t.hit && (idx == IDX_W'(BYTE_W - 1));
        t.idx   = idx;
        return t;
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_tsi_pkg::*;
#(
    parameter int POS_W     = 9,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs,
    input  logic             dly_mode,
    output logic             tap_run,
    output logic [POS_W-1:0] tap_pos
);

    localparam logic [POS_W-1:0] LAST_POS = '1;

    frame_st_e        st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             fs_q;
    logic             fs_start;

    assign fs_start = fs & ~fs_q;

    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        if (fs_start) begin
            st_d  = dly_mode ? FR_ARM : FR_RUN;
            pos_d = '0;
        end else begin
            unique case (st_q)
                FR_ARM: begin
                    st_d  = FR_RUN;
                    pos_d = '0;
                end
                FR_RUN: begin
                    if (pos_q == LAST_POS) begin
                        st_d = FR_IDLE;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
                default: st_d = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FR_IDLE;
            pos_q <= '0;
            fs_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
            fs_q  <= fs;
        end
    end

    generate
        if (LOOKAHEAD) begin : g_next
            assign tap_run = (st_d == FR_RUN);
            assign tap_pos = pos_d;
        end else begin : g_curr
            assign tap_run = (st_q == FR_RUN);
            assign tap_pos = pos_q;
        end
    endgenerate

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_tap_t         tap,
    input  logic              pwr_dn,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              dx_d,
    output logic              dx_en,
    output logic              tx_req
);

    logic [BYTE_W-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            dx_d   <= 1'b0;
            dx_en  <= 1'b0;
            last_q <= 1'b0;
            tx_req <= 1'b0;
        end else begin
            dx_en  <= tap.hit & ~pwr_dn;
            last_q <= tap.last;
            tx_req <= last_q;
            if (tap.first) begin
                sh_q <= tx_byte;
                dx_d <= tx_byte[BYTE_W-1];
            end else if (tap.hit) begin
                dx_d <= sh_q[IDX_W'(BYTE_W - 1) - tap.idx];
            end
        end
    end

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_tap_t         tap,
    input  logic              dr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    logic              smp_q;
    logic [BYTE_W-1:0] sh_q;

    // Mid-interval capture of the line.
    always_ff @(negedge clk) begin
        if (rst) smp_q <= 1'b0;
        else     smp_q <= dr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tap.first) begin
                sh_q <= {{(BYTE_W-1){1'b0}}, smp_q};
            end else if (tap.hit) begin
                sh_q <= {sh_q[BYTE_W-2:0], smp_q};
            end
            if (tap.last) begin
                rx_byte  <= {sh_q[BYTE_W-2:0], smp_q};
                rx_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
    import pcm_tsi_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsx,
    input  logic              fsr,
    input  logic              dly_mode,
    input  logic              pwr_dn,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_req,
    output wire               dx,
    output logic              dx_en,
    input  logic              dr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int POS_W = SLOT_W + IDX_W;

    logic             tx_run, rx_run;
    logic [POS_W-1:0] tx_pos, rx_pos;
    slot_tap_t        tx_tap, rx_tap;
    logic             dx_d;

    // Transmit looks one edge ahead so the output register is loaded for the bit.
    pcm_frame_timer #(.POS_W(POS_W), .LOOKAHEAD(1'b1)) u_tx_timer (
        .clk      (clk),
        .rst      (rst),
        .fs       (fsx),
        .dly_mode (dly_mode),
        .tap_run  (tx_run),
        .tap_pos  (tx_pos)
    );

    // Receive uses the current position: the bit was sampled during it.
    pcm_frame_timer #(.POS_W(POS_W), .LOOKAHEAD(1'b0)) u_rx_timer (
        .clk      (clk),
        .rst      (rst),
        .fs       (fsr),
        .dly_mode (dly_mode),
        .tap_run  (rx_run),
        .tap_pos  (rx_pos)
    );

    assign tx_tap = make_tap(tx_run, tx_pos[POS_W-1:IDX_W] == tx_slot, tx_pos[IDX_W-1:0]);
    assign rx_tap = make_tap(rx_run, rx_pos[POS_W-1:IDX_W] == rx_slot, rx_pos[IDX_W-1:0]);

    pcm_tx_lane u_tx_lane (
        .clk     (clk),
        .rst     (rst),
        .tap     (tx_tap),
        .pwr_dn  (pwr_dn),
        .tx_byte (tx_byte),
        .dx_d    (dx_d),
        .dx_en   (dx_en),
        .tx_req  (tx_req)
    );

    pcm_rx_lane u_rx_lane (
        .clk      (clk),
        .rst      (rst),
        .tap      (rx_tap),
        .dr       (dr),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    assign dx = dx_en ? dx_d : 1'bz;

endmodule

// File: rtl/pcm_tsi_chk.sv
module pcm_tsi_chk (
    input logic clk,
    input logic rst,
    input logic fsx,
    input logic pwr_dn,
    input logic dx_en,
    input logic tx_req,
    input logic rx_valid
);

    logic [3:0] en_len;

    always_ff @(posedge clk) begin
        if (rst)                        en_len <= '0;
        else if (!dx_en)                en_len <= '0;
        else if (en_len != 4'hf)        en_len <= en_len + 1'b1;
    end

    p_slot_len_r2: assert property (@(posedge clk) disable iff (rst)
        en_len <= 4'd8);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);

    p_req_after_slot_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_req) && !$past(pwr_dn) && !fsx) |-> $fell(dx_en));

    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !dx_en);

endmodule

bind pcm_tsi pcm_tsi_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fsx      (fsx),
    .pwr_dn   (pwr_dn),
    .dx_en    (dx_en),
    .tx_req   (tx_req),
    .rx_valid (rx_valid)
);

// File: tb/pcm_tsi_bench.sv
module pcm_tsi_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsx = 1'b0, fsr = 1'b0, dly_mode = 1'b0, pwr_dn = 1'b0, dr = 1'b0;
    logic [5:0] tx_slot = '0, rx_slot = '0;
    logic [7:0] tx_byte = '0;
    wire        dx;
    logic       dx_en, tx_req, rx_valid;
    logic [7:0] rx_byte;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcm_tsi u_pcm_tsi (
        .clk(clk), .rst(rst), .fsx(fsx), .fsr(fsr), .dly_mode(dly_mode),
        .pwr_dn(pwr_dn), .tx_slot(tx_slot), .rx_slot(rx_slot), .tx_byte(tx_byte),
        .tx_req(tx_req), .dx(dx), .dx_en(dx_en), .dr(dr),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One frame: positions computed from the edge the frame syncs are sampled at.
    task automatic run_frame(input bit dly, input int ts, input int rs, input int lag,
                             input logic [7:0] tb, input logic [7:0] rb, input bit pd);
        int d = dly ? 1 : 0;
        step();
        fsx = 1'b1; fsr = (lag == 0); tx_byte = tb; dly_mode = dly; pwr_dn = pd;
        tx_slot = 6'(ts); rx_slot = 6'(rs); dr = 1'b0;
        for (int c = 0; c <= d + lag + 513; c++) begin
            int  pt = c - d;
            int  pr = c - d - lag;
            bit  en_x = !pd && pt >= ts*8 && pt < ts*8 + 8;
            bit  v_x  = (pr == rs*8 + 8);
            step();
            // R2 R3 R4 R8: enable window and data bits
            chk(dx_en == en_x, dly ? "R4/R2 dx_en" : "R3/R2 dx_en", dx_en, en_x);
            if (en_x)
                chk(dx === tb[7-(pt-ts*8)], "R2/R10 dx bit", dx, tb[7-(pt-ts*8)]);
            // R6: request after the slot
            chk(tx_req == (pt == ts*8 + 8), "R6 tx_req", tx_req, pt == ts*8 + 8);
            // R5 R7: receive strobe and byte
            chk(rx_valid == v_x, "R5/R7 rx_valid", rx_valid, v_x);
            if (v_x) chk(rx_byte == rb, "R5 rx_byte", rx_byte, rb);
            fsx = 1'b0;
            fsr = (lag > 0 && c == lag - 1);
            if (pt == ts*8) tx_byte = ~tb;   // R10: change after capture
            if (pr >= rs*8 && pr < rs*8 + 8) dr = rb[7-(pr-rs*8)];
            else                             dr = c[0];
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dl[12] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 1, 0, 0};
        int tsl[12] = '{0, 1, 63, 5, 0, 1, 63, 9, 2, 6, 3, 3};
        int rsl[12] = '{0, 2, 63, 7, 0, 2, 63, 4, 1, 6, 3, 4};
        int lg[12] = '{0, 0, 0, 0, 0, 0, 0, 0, 3, 5, 0, 0};
        int pdl[12] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};

        repeat (3) begin
            step();
            // R1: quiet during reset
            chk(!dx_en && !tx_req && !rx_valid, "R1 reset outputs", {dx_en, tx_req, rx_valid}, 0);
        end
        rst = 1'b0;
        step();
        chk(!dx_en && !tx_req && !rx_valid, "R1 after reset", {dx_en, tx_req, rx_valid}, 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);

        for (int i = 0; i < 12; i++) begin
            logic [7:0] tb = 8'h5a ^ 8'(i * 37);
            logic [7:0] rb = 8'hc3 ^ 8'(i * 29);
            if (i == 11) begin
                // R9: earlier frame sync, then a restart mid-frame
                step();
                fsx = 1'b1; fsr = 1'b1; dly_mode = 1'b0; tx_slot = 6'd3; rx_slot = 6'd4;
                step();
                fsx = 1'b0; fsr = 1'b0;
                repeat (5) step();
            end
            run_frame(dl[i] != 0, tsl[i], rsl[i], lg[i], tb, rb, pdl[i] != 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule